// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts hardware activity for profiling software. It holds one free-running cycle counter and a parameterised bank of event counters, all 32 bits wide. Each event counter carries an 8-bit event selector that picks one of 256 event lines to count. Software reaches everything through a plain register port that has a write strobe, a read strobe and a 4-bit word address. Read data is returned one cycle after the read strobe.

Counters are switched on and off through a pair of set and clear registers. Overflow interrupts are masked through a second pair that works the same way. In every bitmap, bit n belongs to event counter n and bit 31 belongs to the cycle counter. The event counters are reached indirectly: a select register picks the counter that the count-value and event-type registers access. When a counter wraps, it raises a sticky flag. A single interrupt line is high while any flagged counter also has its interrupt enabled.

Top module: `pmu_top`

## Requirements
- R1: After reset all counters, event types, enable masks, interrupt masks, flags and the select register are 0. `irq` and `export_en` are low. The control register reads 0x00002000, which is the counter-count field holding 4.
- R2: Register map:
  - Control register (address 0x0): bit 0 global enable, bit 1 event-counter reset, bit 2 cycle-counter reset, bit 3 divide-by-64, bit 4 export enable (driven on `export_en`), bit 5 debug stop.
  - Only bits 5:0 are writable. Bits 1 and 2 always read 0. Bits 15:11 read the number of event counters.
- R3: Counter enables are changed through two registers:
  - Writing ones to the set register (0x1) enables the matching counters. Writing ones to the clear register (0x2) disables them. Zero bits have no effect.
  - Both registers read the current mask: bit n is event counter n, bit 31 is the cycle counter, and bits with no counter read 0.
- R4: Interrupt enables use the set register 0x3 and the clear register 0x4. They behave exactly as R3.
- R5: A counter that increments from 0xFFFFFFFF to 0 sets its flag at the same edge, at the bit position of R3. The flag register (0x5) reads the flags. Writing ones to it clears the matching flags, and a flag stays set until cleared.
- R6: `irq` is high exactly while some flag has its interrupt-enable bit set.
- R7: Each event counter has its own event type:
  - The select register (0x7) chooses the counter reached through the event-type register (0xA).
  - An event counter advances by one at each clock edge where its selected event line is high, the global enable is set and its own enable bit is set.
- R8: The count-value register (0x9) reads and writes the selected event counter, so a count can be preloaded. A select value with no counter behind it reads 0 and ignores writes.
- R9: Event type 0 is a software increment. Writing a one to bit n of register 0x6 advances counter n when it is enabled and has type 0. A counter of type 0 ignores event line 0, and a counter with another type ignores register 0x6.
- R10: The cycle counter (0x8, writable) advances once per enabled clock. With the divide bit set it advances once per 64 enabled clocks, counted from its last reset.
- R11: While the debug stop bit is set and `dbg_prohibit` is high, the cycle counter holds its value. With the bit clear, `dbg_prohibit` has no effect.
- R12: Writing a one to control bit 1 clears all event counters. Writing a one to bit 2 clears the cycle counter and its prescaler. Neither touches the other kind of counter.
- R13: `reg_rvalid` is high exactly one cycle after `reg_rd`, with `reg_rdata` holding the addressed value as it was at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid |
| evt_in | input | 256 | Event lines, one per event number |
| dbg_prohibit | input | 1 | Debug-prohibit indication |
| export_en | output | 1 | Export enable, control bit 4 |
| irq | output | 1 | Combined overflow interrupt |

## Verification
A register write takes effect at the clock edge that samples it. A counter moves at every edge where its event line or the software-increment write is present. A wrap raises its flag at that same edge, and `irq` follows the flags without a further register stage. Read data arrives one edge after the read strobe. The bench drives inputs and samples outputs on falling edges, so every stimulus counts exactly the rising edges it spans. The expected counts are computed from the number of enabled edges, including the edge that carries the disabling write. Read results are queued in issue order and compared when `reg_rvalid` appears.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam int IDX_W   = 5;
  localparam int CYC_BIT = 31;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_EVRST  = 1;
  localparam int CB_CYRST  = 2;
  localparam int CB_DIV    = 3;
  localparam int CB_EXP    = 4;
  localparam int CB_DBGSTP = 5;
  localparam int CTRL_W    = 6;
  localparam logic [CTRL_W-1:0] CTRL_STORE_MASK = 6'b111001;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 4'h0,
    RA_EN_SET = 4'h1,
    RA_EN_CLR = 4'h2,
    RA_IE_SET = 4'h3,
    RA_IE_CLR = 4'h4,
    RA_FLAGS  = 4'h5,
    RA_SWINC  = 4'h6,
    RA_SEL    = 4'h7,
    RA_CYC    = 4'h8,
    RA_EVCNT  = 4'h9,
    RA_EVTYPE = 4'hA
  } reg_addr_e;
endpackage

// File: rtl/pmu_rst_sync.sv
module pmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/pmu_evt_counter.sv
module pmu_evt_counter #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 8,
  localparam int NUM_EVT = 1 << SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               count_en,
  input  logic [NUM_EVT-1:0] evt_lines,
  input  logic               sw_inc,
  input  logic               clr,
  input  logic               type_we,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic [SEL_W-1:0]   type_wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [SEL_W-1:0]   type_q,
  output logic               inc,
  output logic               ovf
);
  logic             hit;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ld;

  // next state
  always_comb begin
    hit    = (type_q == '0) ? sw_inc : evt_lines[type_q];
    inc    = count_en & hit;
    cnt_d  = cnt_q;
    ovf    = 1'b0;
    cnt_ld = clr | cnt_we | inc;
    if (clr) begin
      cnt_d = '0;
    end else if (cnt_we) begin
      cnt_d = cnt_wdata;
    end else if (inc) begin
      cnt_d = cnt_q + CNT_W'(1);
      ovf   = &cnt_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       type_q <= '0;
    else if (type_we) type_q <= type_wdata;
  end
endmodule

// File: rtl/pmu_cycle_counter.sv
module pmu_cycle_counter #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div_en,
  input  logic             clr,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_ld;
  logic             tick;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_ld;

  // next state
  always_comb begin
    tick   = run & (~div_en | (&pre_q));
    pre_ld = clr | (run & div_en);
    pre_d  = clr ? '0 : pre_q + PRE_W'(1);
    cnt_d  = cnt_q;
    ovf    = 1'b0;
    cnt_ld = clr | we | tick;
    if (clr) begin
      cnt_d = '0;
    end else if (we) begin
      cnt_d = wdata;
    end else if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
      ovf   = &cnt_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_ld) pre_q <= pre_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pmu_regs.sv
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 32,
  parameter int SEL_W   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic                            rvalid,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   evt_vals,
  input  logic [NUM_CNT-1:0][SEL_W-1:0]   evt_types,
  input  logic [CNT_W-1:0]                cyc_val,
  input  logic [NUM_CNT-1:0]              evt_ovf,
  input  logic                            cyc_ovf,
  output logic                            glob_en,
  output logic                            div_en,
  output logic                            export_en,
  output logic                            dbg_stop,
  output logic [DATA_W-1:0]               cnt_en,
  output logic [DATA_W-1:0]               int_en,
  output logic [DATA_W-1:0]               ovf_flags,
  output logic                            evt_clr,
  output logic                            cyc_clr,
  output logic                            cyc_we,
  output logic [NUM_CNT-1:0]              sw_inc,
  output logic [NUM_CNT-1:0]              evt_cnt_we,
  output logic [NUM_CNT-1:0]              evt_type_we,
  output logic                            irq
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    (DATA_W'(1) << CYC_BIT) | ((DATA_W'(1) << NUM_CNT) - DATA_W'(1));
  localparam logic [IDX_W-1:0] NUM_FIELD = IDX_W'(NUM_CNT);

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cen_q, cen_d, ien_q, ien_d, flg_q, flg_d;
  logic [IDX_W-1:0]  sel_q;
  logic [DATA_W-1:0] rdata_q, rd_mux, ovf_vec, wmask;
  logic              rvalid_q;
  logic              wr_ctrl, wr_cset, wr_cclr, wr_iset, wr_iclr;
  logic              wr_flags, wr_swinc, wr_sel, wr_evcnt, wr_evtype;
  logic              flg_ld;
  logic [NUM_CNT-1:0] sel_hit;

  // write decode
  always_comb begin
    wr_ctrl   = wr_en && (addr == RA_CTRL);
    wr_cset   = wr_en && (addr == RA_EN_SET);
    wr_cclr   = wr_en && (addr == RA_EN_CLR);
    wr_iset   = wr_en && (addr == RA_IE_SET);
    wr_iclr   = wr_en && (addr == RA_IE_CLR);
    wr_flags  = wr_en && (addr == RA_FLAGS);
    wr_swinc  = wr_en && (addr == RA_SWINC);
    wr_sel    = wr_en && (addr == RA_SEL);
    cyc_we    = wr_en && (addr == RA_CYC);
    wr_evcnt  = wr_en && (addr == RA_EVCNT);
    wr_evtype = wr_en && (addr == RA_EVTYPE);
    wmask     = wdata & IMPL_MASK;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_sel
      assign sel_hit[gi]     = (sel_q == IDX_W'(gi));
      assign evt_cnt_we[gi]  = wr_evcnt & sel_hit[gi];
      assign evt_type_we[gi] = wr_evtype & sel_hit[gi];
      assign sw_inc[gi]      = wr_swinc & wdata[gi];
    end
  endgenerate

  assign evt_clr = wr_ctrl & wdata[CB_EVRST];
  assign cyc_clr = wr_ctrl & wdata[CB_CYRST];

  // next state of the control and mask registers
  always_comb begin
    ctrl_d = wdata[CTRL_W-1:0] & CTRL_STORE_MASK;
    cen_d  = cen_q;
    if (wr_cset) cen_d = cen_q | wmask;
    if (wr_cclr) cen_d = cen_q & ~wmask;
    ien_d  = ien_q;
    if (wr_iset) ien_d = ien_q | wmask;
    if (wr_iclr) ien_d = ien_q & ~wmask;
    ovf_vec = '0;
    ovf_vec[NUM_CNT-1:0] = evt_ovf;
    ovf_vec[CYC_BIT]     = cyc_ovf;
    flg_d  = (flg_q & ~(wr_flags ? wmask : '0)) | ovf_vec;
    flg_ld = wr_flags | (|ovf_vec);
  end

  // read mux
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      RA_CTRL:   rd_mux = DATA_W'({NUM_FIELD, 5'b00000, ctrl_q});
      RA_EN_SET,
      RA_EN_CLR: rd_mux = cen_q;
      RA_IE_SET,
      RA_IE_CLR: rd_mux = ien_q;
      RA_FLAGS:  rd_mux = flg_q;
      RA_SEL:    rd_mux = DATA_W'(sel_q);
      RA_CYC:    rd_mux = DATA_W'(cyc_val);
      RA_EVCNT: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_hit[i]) rd_mux = DATA_W'(evt_vals[i]);
      end
      RA_EVTYPE: begin
        for (int i = 0; i < NUM_CNT; i++)
          if (sel_hit[i]) rd_mux = DATA_W'(evt_types[i]);
      end
      default:   rd_mux = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cen_q <= '0;
    else if (wr_cset | wr_cclr)  cen_q <= cen_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ien_q <= '0;
    else if (wr_iset | wr_iclr)  ien_q <= ien_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flg_q <= '0;
    else if (flg_ld) flg_q <= flg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (wr_sel) sel_q <= wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rd_en;
  end

  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
  assign glob_en   = ctrl_q[CB_EN];
  assign div_en    = ctrl_q[CB_DIV];
  assign export_en = ctrl_q[CB_EXP];
  assign dbg_stop  = ctrl_q[CB_DBGSTP];
  assign cnt_en    = cen_q;
  assign int_en    = ien_q;
  assign ovf_flags = flg_q;
  assign irq       = |(flg_q & ien_q);
endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_CNT   = 4,
  parameter int CNT_W     = 32,
  parameter int EVT_SEL_W = 8,
  parameter int PRE_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic                        reg_rd,
  input  logic [3:0]                  reg_addr,
  input  logic [31:0]                 reg_wdata,
  output logic [31:0]                 reg_rdata,
  output logic                        reg_rvalid,
  input  logic [(1<<EVT_SEL_W)-1:0]   evt_in,
  input  logic                        dbg_prohibit,
  output logic                        export_en,
  output logic                        irq
);
  logic                              rst_n_s;
  logic                              glob_en, div_en, dbg_stop;
  logic [DATA_W-1:0]                 cnt_en, int_en, ovf_flags;
  logic                              evt_clr, cyc_clr, cyc_we, cyc_ovf, cyc_run;
  logic [NUM_CNT-1:0]                sw_inc, evt_cnt_we, evt_type_we, evt_inc, evt_ovf;
  logic [NUM_CNT-1:0][CNT_W-1:0]     evt_vals;
  logic [NUM_CNT-1:0][EVT_SEL_W-1:0] evt_types;
  logic [CNT_W-1:0]                  cyc_val;

  pmu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  pmu_regs #(
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W),
    .SEL_W   (EVT_SEL_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (reg_wr),
    .rd_en       (reg_rd),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .rdata       (reg_rdata),
    .rvalid      (reg_rvalid),
    .evt_vals    (evt_vals),
    .evt_types   (evt_types),
    .cyc_val     (cyc_val),
    .evt_ovf     (evt_ovf),
    .cyc_ovf     (cyc_ovf),
    .glob_en     (glob_en),
    .div_en      (div_en),
    .export_en   (export_en),
    .dbg_stop    (dbg_stop),
    .cnt_en      (cnt_en),
    .int_en      (int_en),
    .ovf_flags   (ovf_flags),
    .evt_clr     (evt_clr),
    .cyc_clr     (cyc_clr),
    .cyc_we      (cyc_we),
    .sw_inc      (sw_inc),
    .evt_cnt_we  (evt_cnt_we),
    .evt_type_we (evt_type_we),
    .irq         (irq)
  );

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CNT; gc++) begin : g_evt
      pmu_evt_counter #(
        .CNT_W (CNT_W),
        .SEL_W (EVT_SEL_W)
      ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n_s),
        .count_en   (glob_en & cnt_en[gc]),
        .evt_lines  (evt_in),
        .sw_inc     (sw_inc[gc]),
        .clr        (evt_clr),
        .type_we    (evt_type_we[gc]),
        .cnt_we     (evt_cnt_we[gc]),
        .cnt_wdata  (reg_wdata[CNT_W-1:0]),
        .type_wdata (reg_wdata[EVT_SEL_W-1:0]),
        .cnt_q      (evt_vals[gc]),
        .type_q     (evt_types[gc]),
        .inc        (evt_inc[gc]),
        .ovf        (evt_ovf[gc])
      );
    end
  endgenerate

  assign cyc_run = glob_en & cnt_en[CYC_BIT] & ~(dbg_stop & dbg_prohibit);

  pmu_cycle_counter #(
    .CNT_W (CNT_W),
    .PRE_W (PRE_W)
  ) u_cyc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .run    (cyc_run),
    .div_en (div_en),
    .clr    (cyc_clr),
    .we     (cyc_we),
    .wdata  (reg_wdata[CNT_W-1:0]),
    .cnt_q  (cyc_val),
    .ovf    (cyc_ovf)
  );
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [3:0]       reg_addr,
  input logic             wd31,
  input logic [1:0]       rdata_rst_bits,
  input logic             reg_rvalid,
  input logic             irq,
  input logic [31:0]      int_en,
  input logic             flag0,
  input logic             flag31,
  input logic             cyc_en,
  input logic             glob_en,
  input logic [CNT_W-1:0] cyc_val,
  input logic             cyc_clr,
  input logic             cyc_we,
  input logic [CNT_W-1:0] cnt0,
  input logic             inc0,
  input logic             wr0,
  input logic             evt_clr
);
  // R13: read data valid exactly one cycle after the strobe
  p_rvalid_follows_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);
  p_no_spurious_rvalid_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  // R2: reset bits of the control register read as zero
  p_ctrl_selfclear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 4'h0) |=> (rdata_rst_bits == 2'b00));

  // R3: clearing the cycle enable takes effect at the write edge
  p_en_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h2 && wd31) |=> !cyc_en);

  // R5: wrap of event counter 0 raises its flag
  p_evt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt0 == '1 && inc0 && !wr0 && !evt_clr) |=> flag0);

  // R5: cycle flag stays until a one is written to it
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag31 && !(reg_wr && reg_addr == 4'h5 && wd31)) |=> flag31);

  // R6: no interrupt while every interrupt enable is clear
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == 32'h0) |-> !irq);

  // R10: cycle counter frozen without global enable
  p_cyc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!glob_en && !cyc_clr && !cyc_we) |=> $stable(cyc_val));

  // R12: event reset clears counter 0
  p_evt_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
    evt_clr |=> (cnt0 == '0));
endmodule

bind pmu_top pmu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_s),
  .reg_wr         (reg_wr),
  .reg_rd         (reg_rd),
  .reg_addr       (reg_addr),
  .wd31           (reg_wdata[31]),
  .rdata_rst_bits (reg_rdata[2:1]),
  .reg_rvalid     (reg_rvalid),
  .irq            (irq),
  .int_en         (int_en),
  .flag0          (ovf_flags[0]),
  .flag31         (ovf_flags[31]),
  .cyc_en         (cnt_en[31]),
  .glob_en        (glob_en),
  .cyc_val        (cyc_val),
  .cyc_clr        (cyc_clr),
  .cyc_we         (cyc_we),
  .cnt0           (evt_vals[0]),
  .inc0           (evt_inc[0]),
  .wr0            (evt_cnt_we[0]),
  .evt_clr        (evt_clr)
);

// File: tb/tb_pmu_top.sv
module tb_pmu_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_ENS = 4'h1, A_ENC = 4'h2, A_IES = 4'h3,
                         A_IEC = 4'h4, A_FLG = 4'h5, A_SWI = 4'h6, A_SEL = 4'h7,
                         A_CYC = 4'h8, A_CNT = 4'h9, A_TYP = 4'hA;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         reg_wr, reg_rd;
  logic [3:0]   reg_addr;
  logic [31:0]  reg_wdata;
  logic [31:0]  reg_rdata;
  logic         reg_rvalid;
  logic [255:0] evt_in;
  logic         dbg_prohibit;
  logic         export_en, irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  pmu_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .evt_in(evt_in), .dbg_prohibit(dbg_prohibit),
    .export_en(export_en), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard whenever read data appears
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(32'h1, 32'h0, "R13 read data without pending read");
      end else begin
        logic [31:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(reg_rdata, e, t);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_in = '0; dbg_prohibit = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk({31'b0, irq}, 32'h0, "R1 irq after reset");
    chk({31'b0, export_en}, 32'h0, "R1 export_en after reset");
    rd(A_CTRL, 32'h0000_2000, "R1 ctrl reset value");
    rd(A_ENS, 32'h0, "R1 enable mask reset");
    rd(A_IES, 32'h0, "R1 irq mask reset");
    rd(A_FLG, 32'h0, "R1 flags reset");
    rd(A_CYC, 32'h0, "R1 cycle counter reset");
    rd(A_CNT, 32'h0, "R1 event counter reset");
    rd(A_SEL, 32'h0, "R1 select reset");

    // R13 timing of one read
    reg_rd = 1'b1; reg_addr = A_TYP;
    exp_q.push_back(32'h0); tag_q.push_back("R1 event type reset");
    @(negedge clk);
    reg_rd = 1'b0;
    chk({31'b0, reg_rvalid}, 32'h1, "R13 rvalid one cycle after read");
    idle(1);
    chk({31'b0, reg_rvalid}, 32'h0, "R13 rvalid drops");

    // R2 control register
    wr(A_CTRL, 32'hFFFF_FFFF);
    chk({31'b0, export_en}, 32'h1, "R2 export_en follows bit 4");
    rd(A_CTRL, 32'h0000_2039, "R2 writable bits, reset bits read 0");
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, 32'h0000_2000, "R2 ctrl cleared");

    // R3 enable set/clear
    wr(A_ENS, 32'hFFFF_FFFF);
    rd(A_ENS, 32'h8000_000F, "R3 set reads implemented bits");
    rd(A_ENC, 32'h8000_000F, "R3 clear register reads mask");
    wr(A_ENC, 32'h8000_0001);
    rd(A_ENS, 32'h0000_000E, "R3 clear ones");
    wr(A_ENS, 32'h0);
    rd(A_ENS, 32'h0000_000E, "R3 zero bits no effect");
    wr(A_ENC, 32'hFFFF_FFFF);
    rd(A_ENC, 32'h0, "R3 clear all");

    // R4 interrupt enable set/clear
    wr(A_IES, 32'h8000_0002);
    rd(A_IEC, 32'h8000_0002, "R4 irq mask set");
    wr(A_IEC, 32'h0000_0002);
    rd(A_IES, 32'h8000_0000, "R4 irq mask clear one bit");
    wr(A_IEC, 32'h8000_0000);
    rd(A_IES, 32'h0, "R4 irq mask empty");

    // R7 event type and counting
    wr(A_SEL, 0); wr(A_TYP, 5);
    wr(A_SEL, 1); wr(A_TYP, 7);
    rd(A_TYP, 32'h7, "R7 type of counter 1");
    wr(A_SEL, 0);
    rd(A_TYP, 32'h5, "R7 type of counter 0");
    wr(A_ENS, 32'h3);
    evt_in[5] = 1'b1; idle(4); evt_in[5] = 1'b0;
    rd(A_CNT, 32'h0, "R7 no count without global enable");
    wr(A_CTRL, 32'h1);
    evt_in[5] = 1'b1; idle(6); evt_in[5] = 1'b0;
    rd(A_CNT, 32'h6, "R7 six event cycles");
    wr(A_ENC, 32'h1);
    evt_in[5] = 1'b1; evt_in[7] = 1'b1; idle(3); evt_in[5] = 1'b0; evt_in[7] = 1'b0;
    rd(A_CNT, 32'h6, "R7 own enable gates counter 0");
    wr(A_SEL, 1);
    rd(A_CNT, 32'h3, "R7 counter 1 counts its own line");
    wr(A_SEL, 0);
    wr(A_ENS, 32'h1);
    for (int i = 0; i < 8; i++) begin
      evt_in[5] = (i % 2 == 0);
      @(negedge clk);
    end
    evt_in[5] = 1'b0;
    rd(A_CNT, 32'hA, "R7 alternating event pattern");

    // R8 indirect value access and preload
    wr(A_SEL, 2); wr(A_CNT, 32'h1234_5678);
    rd(A_CNT, 32'h1234_5678, "R8 preload counter 2");
    rd(A_SEL, 32'h2, "R8 select readback");
    wr(A_SEL, 6); wr(A_CNT, 32'h0000_DEAD);
    rd(A_CNT, 32'h0, "R8 unimplemented select reads 0");
    wr(A_SEL, 2);
    rd(A_CNT, 32'h1234_5678, "R8 write to unimplemented ignored");

    // R9 software increment
    wr(A_CNT, 32'h0);
    wr(A_SEL, 3); wr(A_TYP, 5); wr(A_CNT, 32'h0);
    wr(A_ENS, 32'hC);
    wr(A_SWI, 32'hC); wr(A_SWI, 32'hC); wr(A_SWI, 32'hC);
    rd(A_CNT, 32'h0, "R9 non-zero type ignores increment register");
    wr(A_SEL, 2);
    rd(A_CNT, 32'h3, "R9 three software increments");
    evt_in[0] = 1'b1; idle(3); evt_in[0] = 1'b0;
    rd(A_CNT, 32'h3, "R9 type 0 ignores event line 0");

    // R5 / R6 overflow and interrupt
    wr(A_SEL, 1); wr(A_CNT, 32'hFFFF_FFFE);
    wr(A_IES, 32'h2);
    evt_in[7] = 1'b1; idle(2); evt_in[7] = 1'b0;
    chk({31'b0, irq}, 32'h1, "R6 irq on enabled flag");
    rd(A_FLG, 32'h2, "R5 flag of counter 1");
    rd(A_CNT, 32'h0, "R5 counter wrapped to 0");
    wr(A_FLG, 32'h1);
    rd(A_FLG, 32'h2, "R5 other flag write leaves flag");
    chk({31'b0, irq}, 32'h1, "R6 irq held");
    wr(A_FLG, 32'h2);
    rd(A_FLG, 32'h0, "R5 write one clears flag");
    chk({31'b0, irq}, 32'h0, "R6 irq drops after clear");
    wr(A_SEL, 2); wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_SWI, 32'h4);
    chk({31'b0, irq}, 32'h0, "R6 masked flag gives no irq");
    rd(A_FLG, 32'h4, "R5 flag from software increment wrap");
    wr(A_IES, 32'h4);
    chk({31'b0, irq}, 32'h1, "R6 irq after unmask");
    wr(A_FLG, 32'h4);
    chk({31'b0, irq}, 32'h0, "R6 irq after flag clear");
    wr(A_IEC, 32'hFFFF_FFFF);

    // R12 event counter reset leaves cycle counter
    wr(A_CYC, 32'h77);
    wr(A_CTRL, 32'h3);
    wr(A_SEL, 0);
    rd(A_CNT, 32'h0, "R12 event counters reset");
    rd(A_CYC, 32'h77, "R12 cycle counter untouched by event reset");

    // R10 cycle counting
    wr(A_CTRL, 32'h0);
    wr(A_ENS, 32'h8000_0000);
    wr(A_CTRL, 32'h5); idle(19); wr(A_CTRL, 32'h0);
    rd(A_CYC, 32'd20, "R10 twenty enabled clocks");
    wr(A_CTRL, 32'hD); idle(199); wr(A_CTRL, 32'h8);
    rd(A_CYC, 32'd3, "R10 divide by 64 over 200 clocks");

    // R11 debug stop
    dbg_prohibit = 1'b1;
    wr(A_CTRL, 32'h25); idle(9); wr(A_CTRL, 32'h20);
    rd(A_CYC, 32'h0, "R11 frozen while prohibited");
    wr(A_CTRL, 32'h5); idle(9); wr(A_CTRL, 32'h0);
    rd(A_CYC, 32'd10, "R11 prohibit ignored without stop bit");
    dbg_prohibit = 1'b0;

    // R5 cycle counter wrap at bit 31
    wr(A_CYC, 32'hFFFF_FFFF);
    wr(A_IES, 32'h8000_0000);
    wr(A_CTRL, 32'h1); wr(A_CTRL, 32'h0);
    rd(A_CYC, 32'h0, "R5 cycle counter wrapped");
    rd(A_FLG, 32'h8000_0000, "R5 cycle flag at bit 31");
    chk({31'b0, irq}, 32'h1, "R6 irq from cycle flag");
    wr(A_FLG, 32'h8000_0000);
    rd(A_FLG, 32'h0, "R5 cycle flag cleared");

    // R12 cycle reset leaves event counters
    wr(A_SEL, 0); wr(A_CNT, 32'h55);
    wr(A_CYC, 32'h99);
    wr(A_CTRL, 32'h4);
    rd(A_CYC, 32'h0, "R12 cycle reset");
    rd(A_CNT, 32'h55, "R12 event counter untouched by cycle reset");

    idle(4);
    if (exp_q.size() != 0) chk(exp_q.size(), 0, "R13 reads left unanswered");
    finish_run();
  end
endmodule